// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the byte-wide datapath of a microcontroller with a single working register. Each cycle it takes the working-register value, a second operand (a file-register byte or an instruction literal), an operation code and the incoming carry, nibble-carry and zero flags. It returns the result byte, the new value of each flag with a write enable per flag, the destination choice (working register or file register) and a zero-result indication for the skip-if-zero forms of increment and decrement.

Subtraction follows the no-borrow convention: carry set means that no borrow occurred. The nibble-carry reports the same thing for the low half of the word. Every operation writes only its own subset of the flags. A flag that an operation does not write is returned with the value it came in with. The arithmetic is combinational. A parameter selects whether the output passes through one register stage or leaves the block directly.

Top module: `acc_alu`

## Requirements
- R1: ADD (code 0) gives opnd+W; ADDC (code 1) gives opnd+W+C_in. Both write C (carry out of bit 7), DC (carry out of bit 3) and Z.
- R2: SUB (code 2) gives opnd−W; SUBB (code 3) gives opnd−W−(NOT C_in). C is set when no borrow occurs over the whole word. DC is set when no borrow occurs in the low nibble. C, DC and Z are written.
- R3: RSUBL (code 4) gives literal−W (the operand minus W, never W minus the operand), sets flags as in R2 and always selects the working register as destination (dst_f_o=0).
- R4: AND (5), OR (6), XOR (7) of operand and W, complement of the operand (8) and move-file (17, result = operand) write only Z.
- R5: INC (9) and DEC (10) return operand±1 and write only Z. INCSZ (11) and DECSZ (12) return the same values, write no flag, and assert zskip_o exactly when the result is zero.
- R6: RL (13) shifts left with C_in into bit 0 and bit 7 out to C. RR (14) shifts right with C_in into bit 7 and bit 0 out to C. Both write C and Z only.
- R7: SWAP (15) exchanges the operand's upper and lower nibbles and writes no flag.
- R8: CLR (16) gives a result of 0 and writes Z=1 only.
- R9: MOVL (18) returns the literal with dst_f_o=0. MOVW (19) returns W with dst_f_o=1. Neither writes a flag.
- R10: For every code other than 4, 18 and 19, dst_f_o equals d_i (0 = working register, 1 = file register).
- R11: A flag whose enable is low is output equal to its incoming value. Whenever Z is written, z_o equals (result == 0).
- R12: With REG_OUT=1 the outputs appear one clock after the inputs. While rst_n is low, every output is 0.
- R13: Codes 20 to 31 write no flag, keep zskip_o low and return the operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_i | input | 5 | Operation code |
| w_i | input | DATA_W | Working-register operand |
| opnd_i | input | DATA_W | File-register or literal operand |
| c_i | input | 1 | Incoming carry flag |
| dc_i | input | 1 | Incoming nibble-carry flag |
| z_i | input | 1 | Incoming zero flag |
| d_i | input | 1 | Destination bit of the instruction |
| res_o | output | DATA_W | Result byte |
| c_o | output | 1 | Carry flag out |
| dc_o | output | 1 | Nibble-carry flag out |
| z_o | output | 1 | Zero flag out |
| c_we_o | output | 1 | Carry write enable |
| dc_we_o | output | 1 | Nibble-carry write enable |
| z_we_o | output | 1 | Zero write enable |
| dst_f_o | output | 1 | 1 selects the file register as destination, 0 the working register |
| zskip_o | output | 1 | Zero-result indication of the skip forms |

## Verification
The sweep pairs operand values so that the low nibbles fall on both sides of each other, with C_in at 0 and at 1, for every code including several undefined ones. This exposes two kinds of fault: a design that takes the nibble borrow from the wrong operand, and one that handles the subtract-with-borrow carry-in with the wrong polarity. The directed cases cover 0xFF+1 (result 0 with both carries set), 0−0 with borrow (0xFF with C cleared), increment-skip from 0xFF and decrement-skip from 1. A design that wrote flags on the skip forms, or that reversed the operand order of the literal subtract, shows a wrong enable or a wrong result in those cases. Rotates with a set incoming carry catch a rotate that drops the carry-in, and the flags passed through unchanged catch an enable that is raised where it should not be.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBB  = 5'd3,
        OP_RSUBL = 5'd4,
        OP_AND   = 5'd5,
        OP_OR    = 5'd6,
        OP_XOR   = 5'd7,
        OP_COM   = 5'd8,
        OP_INC   = 5'd9,
        OP_DEC   = 5'd10,
        OP_INCSZ = 5'd11,
        OP_DECSZ = 5'd12,
        OP_RL    = 5'd13,
        OP_RR    = 5'd14,
        OP_SWAP  = 5'd15,
        OP_CLR   = 5'd16,
        OP_MOVF  = 5'd17,
        OP_MOVL  = 5'd18,
        OP_MOVW  = 5'd19
    } alu_op_e;
endpackage

// File: rtl/acc_arith.sv
// Shared adder for add, add-with-carry, subtract and subtract-with-borrow.
// Subtraction adds the inverted W, so carry-out is the no-borrow flag.
module acc_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic              sub_i,
    input  logic              use_c_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              co_o,
    output logic              hc_o
);
    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W-1:0] b_opnd;
    logic              cin;
    logic [DATA_W:0]   full_sum;
    logic [NIB_W:0]    low_sum;

    always_comb begin
        b_opnd   = sub_i ? ~w_i : w_i;
        cin      = use_c_i ? c_i : sub_i;
        full_sum = {1'b0, a_i} + {1'b0, b_opnd} + {{DATA_W{1'b0}}, cin};
        low_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_opnd[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};
    end

    assign sum_o = full_sum[DATA_W-1:0];
    assign co_o  = full_sum[DATA_W];
    assign hc_o  = low_sum[NIB_W];
endmodule

// File: rtl/acc_logic.sv
// Non-arithmetic results: bitwise, step, rotate, swap and move operations.
module acc_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              rot_c_o
);
    localparam int NIB_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        res_o   = a_i;
        rot_c_o = c_i;
        case (op_i)
            OP_AND:            res_o = a_i & w_i;
            OP_OR:             res_o = a_i | w_i;
            OP_XOR:            res_o = a_i ^ w_i;
            OP_COM:            res_o = ~a_i;
            OP_INC, OP_INCSZ:  res_o = a_i + ONE;
            OP_DEC, OP_DECSZ:  res_o = a_i - ONE;
            OP_RL: begin
                res_o   = {a_i[DATA_W-2:0], c_i};
                rot_c_o = a_i[DATA_W-1];
            end
            OP_RR: begin
                res_o   = {c_i, a_i[DATA_W-1:1]};
                rot_c_o = a_i[0];
            end
            OP_SWAP:           res_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
            OP_CLR:            res_o = '0;
            OP_MOVW:           res_o = w_i;
            default:           res_o = a_i;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              c_i,
    input  logic              dc_i,
    input  logic              z_i,
    input  logic              d_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              dc_o,
    output logic              z_o,
    output logic              c_we_o,
    output logic              dc_we_o,
    output logic              z_we_o,
    output logic              dst_f_o,
    output logic              zskip_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              c;
        logic              dc;
        logic              z;
        logic              c_we;
        logic              dc_we;
        logic              z_we;
        logic              dst_f;
        logic              zskip;
    } alu_out_t;

    alu_op_e           op;
    logic              is_sub;
    logic              is_cin;
    logic [DATA_W-1:0] arith_res;
    logic              arith_co;
    logic              arith_hc;
    logic [DATA_W-1:0] logic_res;
    logic              rot_c;
    alu_out_t          out_d;
    alu_out_t          out_q;

    assign op     = alu_op_e'(op_i);
    assign is_sub = (op == OP_SUB) || (op == OP_SUBB) || (op == OP_RSUBL);
    assign is_cin = (op == OP_ADDC) || (op == OP_SUBB);

    acc_arith #(.DATA_W(DATA_W)) u_arith (
        .a_i     (opnd_i),
        .w_i     (w_i),
        .sub_i   (is_sub),
        .use_c_i (is_cin),
        .c_i     (c_i),
        .sum_o   (arith_res),
        .co_o    (arith_co),
        .hc_o    (arith_hc)
    );

    acc_logic #(.DATA_W(DATA_W)) u_logic (
        .op_i    (op),
        .a_i     (opnd_i),
        .w_i     (w_i),
        .c_i     (c_i),
        .res_o   (logic_res),
        .rot_c_o (rot_c)
    );

    always_comb begin
        out_d       = '0;
        out_d.res   = logic_res;
        out_d.c     = c_i;
        out_d.dc    = dc_i;
        out_d.z     = z_i;
        out_d.dst_f = d_i;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUBL: begin
                out_d.res   = arith_res;
                out_d.c     = arith_co;
                out_d.dc    = arith_hc;
                out_d.c_we  = 1'b1;
                out_d.dc_we = 1'b1;
                out_d.z_we  = 1'b1;
                if (op == OP_RSUBL) out_d.dst_f = 1'b0;
            end
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_INC, OP_DEC, OP_CLR, OP_MOVF:
                out_d.z_we = 1'b1;
            OP_INCSZ, OP_DECSZ:
                out_d.zskip = (logic_res == '0);
            OP_RL, OP_RR: begin
                out_d.c    = rot_c;
                out_d.c_we = 1'b1;
                out_d.z_we = 1'b1;
            end
            OP_MOVL: out_d.dst_f = 1'b0;
            OP_MOVW: out_d.dst_f = 1'b1;
            default: ;
        endcase
        if (out_d.z_we) out_d.z = (out_d.res == '0);
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_comb
            assign out_q = rst_n ? out_d : '0;
        end
    endgenerate

    assign res_o   = out_q.res;
    assign c_o     = out_q.c;
    assign dc_o    = out_q.dc;
    assign z_o     = out_q.z;
    assign c_we_o  = out_q.c_we;
    assign dc_we_o = out_q.dc_we;
    assign z_we_o  = out_q.z_we;
    assign dst_f_o = out_q.dst_f;
    assign zskip_o = out_q.zskip;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] w_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [DATA_W-1:0] res_o,
    input logic              z_o,
    input logic              c_we_o,
    input logic              dc_we_o,
    input logic              z_we_o,
    input logic              dst_f_o,
    input logic              zskip_o
);
    localparam int NIB_W = DATA_W / 2;

    // R11
    z_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_we_o |-> (z_o == (res_o == '0)));

    // R5
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zskip_o |-> (!c_we_o && !dc_we_o && !z_we_o && res_o == '0));

    // R1
    dc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_we_o |-> c_we_o);

    generate
        if (REG_OUT) begin : g_seq
            // R9
            movw_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(op_i) == OP_MOVW) |->
                (res_o == $past(w_i) && dst_f_o && !c_we_o && !z_we_o));
            // R7
            swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(op_i) == OP_SWAP) |->
                (res_o == {$past(opnd_i[NIB_W-1:0]), $past(opnd_i[DATA_W-1:NIB_W])}
                 && !c_we_o && !dc_we_o && !z_we_o));
        end else begin : g_comb
            // R9
            movw_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_MOVW) |-> (res_o == w_i && dst_f_o && !c_we_o));
            // R7
            swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_SWAP) |->
                (res_o == {opnd_i[NIB_W-1:0], opnd_i[DATA_W-1:NIB_W]} && !z_we_o));
        end
    endgenerate
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .w_i     (w_i),
    .opnd_i  (opnd_i),
    .res_o   (res_o),
    .z_o     (z_o),
    .c_we_o  (c_we_o),
    .dc_we_o (dc_we_o),
    .z_we_o  (z_we_o),
    .dst_f_o (dst_f_o),
    .zskip_o (zskip_o)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] w_i = '0;
    logic [7:0] opnd_i = '0;
    logic       c_i = 1'b0, dc_i = 1'b0, z_i = 1'b0, d_i = 1'b0;
    logic [7:0] res_o;
    logic       c_o, dc_o, z_o, c_we_o, dc_we_o, z_we_o, dst_f_o, zskip_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_alu #(.DATA_W(8), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .w_i(w_i), .opnd_i(opnd_i),
        .c_i(c_i), .dc_i(dc_i), .z_i(z_i), .d_i(d_i),
        .res_o(res_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o),
        .c_we_o(c_we_o), .dc_we_o(dc_we_o), .z_we_o(z_we_o),
        .dst_f_o(dst_f_o), .zskip_o(zskip_o)
    );

    function automatic string tag_of(int op);
        case (op)
            0, 1:              return "R1";
            2, 3:              return "R2";
            4:                 return "R3";
            5, 6, 7, 8, 17:    return "R4";
            9, 10, 11, 12:     return "R5";
            13, 14:            return "R6";
            15:                return "R7";
            16:                return "R8";
            18, 19:            return "R9";
            default:           return "R13";
        endcase
    endfunction

    // Expected packed outputs {res, c, dc, z, c_we, dc_we, z_we, dst_f, zskip}
    function automatic logic [15:0] model(int op, int w, int f, int c, int dc, int z, int d);
        int r = f; int co = c; int dco = dc; int zo = z;
        int cw = 0; int dw = 0; int zw = 0; int dst = d; int sk = 0; int b;
        case (op)
            0: begin r = f + w; co = (r > 255); dco = ((f & 15) + (w & 15)) > 15; cw = 1; dw = 1; zw = 1; end
            1: begin r = f + w + c; co = (r > 255); dco = ((f & 15) + (w & 15) + c) > 15; cw = 1; dw = 1; zw = 1; end
            2, 4: begin r = f - w; co = (f >= w); dco = ((f & 15) >= (w & 15)); cw = 1; dw = 1; zw = 1;
                        if (op == 4) dst = 0; end
            3: begin b = (c == 0) ? 1 : 0; r = f - w - b; co = (f >= w + b); dco = ((f & 15) >= (w & 15) + b);
                     cw = 1; dw = 1; zw = 1; end
            5: begin r = f & w; zw = 1; end
            6: begin r = f | w; zw = 1; end
            7: begin r = f ^ w; zw = 1; end
            8: begin r = ~f; zw = 1; end
            9: begin r = f + 1; zw = 1; end
            10: begin r = f - 1; zw = 1; end
            11: begin r = f + 1; sk = ((r & 255) == 0); end
            12: begin r = f - 1; sk = ((r & 255) == 0); end
            13: begin r = (f << 1) | c; co = (f >> 7) & 1; cw = 1; zw = 1; end
            14: begin r = (f >> 1) | (c << 7); co = f & 1; cw = 1; zw = 1; end
            15: r = ((f & 15) << 4) | (f >> 4);
            16: begin r = 0; zw = 1; end
            17: zw = 1;
            18: dst = 0;
            19: begin r = w; dst = 1; end
            default: ;
        endcase
        r = r & 255;
        if (zw != 0) zo = (r == 0);
        return {r[7:0], co[0], dco[0], zo[0], cw[0], dw[0], zw[0], dst[0], sk[0]};
    endfunction

    function automatic logic [15:0] got_vec();
        return {res_o, c_o, dc_o, z_o, c_we_o, dc_we_o, z_we_o, dst_f_o, zskip_o};
    endfunction

    task automatic compare(string req, logic [15:0] exp_v);
        checks++;
        if (got_vec() !== exp_v) begin
            errors++;
            $display("FAIL %s op=%0d w=%02h f=%02h c=%0d: got %04h expected %04h",
                     req, op_i, w_i, opnd_i, c_i, got_vec(), exp_v);
        end
    endtask

    task automatic run(int op, int w, int f, int c, int dc, int z, int d);
        @(negedge clk);
        op_i = op[4:0]; w_i = w[7:0]; opnd_i = f[7:0];
        c_i = c[0]; dc_i = dc[0]; z_i = z[0]; d_i = d[0];
        @(posedge clk);
        #1;
        // R12: registered result visible one clock after the inputs
        compare(tag_of(op), model(op, w, f, c, dc, z, d));
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        op_i = 5'd0; w_i = 8'hA5; opnd_i = 8'h5A; c_i = 1'b1; dc_i = 1'b1; z_i = 1'b1; d_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        compare("R12", 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed boundary cases
        run(0, 8'h01, 8'hFF, 0, 0, 0, 1);   // R1 wrap to zero, C and DC set
        run(1, 8'h0F, 8'hF0, 1, 0, 0, 0);   // R1 carry-in ripples through
        run(3, 8'h00, 8'h00, 0, 0, 0, 1);   // R2 borrow-in gives 0xFF, C clear
        run(3, 8'h10, 8'h10, 1, 0, 0, 1);   // R2 no borrow-in, zero result
        run(2, 8'h01, 8'h10, 0, 1, 1, 0);   // R2 nibble borrow only
        run(4, 8'h20, 8'h05, 1, 1, 0, 1);   // R3 literal minus W, dst forced
        run(11, 8'h00, 8'hFF, 1, 1, 0, 1);  // R5 skip form wraps to zero
        run(12, 8'h00, 8'h01, 0, 0, 1, 1);  // R5 skip form reaches zero
        run(13, 8'h00, 8'h80, 1, 0, 1, 1);  // R6 rotate left with carry
        run(14, 8'h00, 8'h01, 1, 1, 1, 0);  // R6 rotate right with carry
        run(16, 8'h33, 8'h77, 1, 1, 0, 0);  // R8 clear to W
        run(18, 8'h44, 8'h00, 1, 0, 1, 1);  // R9 move literal to W, flags kept
        run(9, 8'h00, 8'h7F, 1, 1, 1, 1);   // R10 file destination follows d

        // Sweep all defined codes and a few undefined ones; R10 and R11 in each
        for (int op = 0; op < 24; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    for (int c = 0; c < 2; c++) begin
                        run(op, (i * 16 + ((i * 7) & 15)) & 255,
                                (j * 16 + ((j * 11 + 3) & 15)) & 255,
                                c, (i ^ j) & 1, ((i + c) >> 1) & 1, (i + j + c) & 1);
                    end
                end
            end
        end

        // R12: asynchronous reset clears outputs mid-run
        run(0, 8'h12, 8'h34, 0, 0, 0, 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        compare("R12", 16'h0000);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule